// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single transfer requests from an internal core into bus cycles on a shared bus. The bus has 16 data bits and a 20-bit address. The low sixteen lines carry the address in the first clock of a cycle and data after that. Four upper lines carry the top address bits in the first clock and status bits after that. A high-byte enable and the address bit 0 select the byte lanes. A read strobe, an active-low signal, marks the read data window. A three-bit cycle code tells an external decoder what kind of cycle is running and when it starts and ends. The device being accessed stretches a cycle by holding `ready` low. A word access to an odd address becomes two byte cycles, and the core sees them as a single transfer.

The controller has eight named states:
- `PH_IDLE`: the bus is quiet.
- `PH_ANN`: announce; the cycle code is shown one clock before the address.
- `PH_T1`: the address phase.
- `PH_T2` and `PH_T3`: the data phases.
- `PH_TW`: a wait state.
- `PH_T4`: the closing phase.
- `PH_HOLD`: the bus is released to another master.

The transitions are:
- IDLE→HOLD when `hold_req` is high.
- IDLE→ANN when a request is taken.
- ANN→T1, T1→T2 and T2→T3 always.
- T3→T4 or TW→T4 when `ready` is high.
- T3→TW or TW→TW when `ready` is low.
- T4→T1 when the second half of a split is pending, or when a new request is taken.
- T4→HOLD when `hold_req` is high.
- T4→IDLE otherwise.
- HOLD→IDLE when `hold_req` falls.

The bus outputs come as value/enable pairs, so the tri-state drivers can sit at the pad level.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the state is idle, and the outputs are: `rd_n`=1, `bhe_n`=1, `status`=3'b111, `ad_oe`=0, `as_oe`=1, `hold_ack`=0 and `done`=0.
- R2: A request taken in idle (`req_ack`=1 in that clock) is followed by one announce clock, then T1, T2 and T3, and then T4 when `ready` is high in T3. `done` is 1 only in the T4 that ends the transfer.
- R3: In T1, `ad_oe`=1 and `ad_out` equals address bits 15:0. `as_out` equals address bits 19:16 for memory cycles (`req_io`=0) and 0 for I/O cycles.
- R4: In T1, `bhe_n` is 0 exactly when the upper lane takes part, which is for an even word or an odd-address byte. Address bit 0 is 0 exactly when the lower lane takes part.
- R5: From T2 through T4, `as_out` carries {0, `int_en` as sampled on the previous clock, `req_seg`[1:0]} (bit 3 down to bit 0). `bhe_n` is 1.
- R6: During T2, T3 and every wait state of a read, `rd_n`=0 and `ad_oe`=0. At all other times `rd_n`=1.
- R7: A write drives `ad_out` with `ad_oe`=1 from T2 through T4. An even word appears as is. A byte appears on both lanes.
- R8: `status` (bits S2 S1 S0) shows the cycle code in announce, T1 and T2, and in T3 or a wait state while `ready` is low. It is 3'b111 in the T3 or wait state where `ready` is high. The codes are: memory read 101, memory write 110, I/O read 001, I/O write 010.
- R9: Each clock in T3 or in a wait state with `ready` low adds one wait state. T4 follows the first such clock that has `ready` high.
- R10: Read data is captured in the T3 or wait state where `ready` is high, and is presented on `rdata` with `done`. A byte comes back in `rdata`[7:0] with the upper byte 0. On an odd byte it is taken from lane 15:8.
- R11: A word at an odd address runs two byte cycles. The first uses the upper lane at the address itself and carries the low byte. The second uses the lower lane at the address plus one (modulo 2^20) and carries the high byte. The second cycle's code shows in the first cycle's T4.
- R12: A request present in T4 shows its code in that T4, is taken there, and goes to T1 with no announce clock.
- R13: When `hold_req` is seen in idle, or in a T4 with no split pending, requests are refused. `hold_ack`=1 follows, and `ad_oe`, `as_oe`, `bhe_oe` and `rd_oe` are 0 with `status`=3'b111. A pending split half runs before the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ack | output | 1 | Request taken this clock |
| req_addr | input | 20 | Byte address |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_seg | input | 2 | Segment tag shown as status |
| int_en | input | 1 | Interrupt-enable flag shown as status |
| done | output | 1 | Transfer complete pulse |
| rdata | output | 16 | Read result, valid with done |
| ready | input | 1 | Device ready, active high |
| hold_req | input | 1 | Bus request from another master |
| hold_ack | output | 1 | Bus released |
| ad_out | output | 16 | Address/data value |
| ad_oe | output | 1 | Address/data drive enable |
| ad_in | input | 16 | Address/data read value |
| as_out | output | 4 | Upper address / status value |
| as_oe | output | 1 | Upper lines drive enable |
| bhe_n | output | 1 | High-byte enable, active low |
| bhe_oe | output | 1 | High-byte enable drive enable |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Read strobe drive enable |
| status | output | 3 | Cycle code S2..S0 |

## Verification
The bench builds the block with its default widths: a 20-bit address over a 16-bit bus, which gives two byte lanes and four upper lines. With these widths, an odd word at 0x0FFFF splits into a second cycle at 0x10000. This makes the upper address lines change between the two halves and tests the address increment across the 16-bit boundary. The vectors use zero to three wait states, so the status return to passive and the strobe timing are checked with and without stretching.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ANN,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_TW,
        PH_T4,
        PH_HOLD
    } phase_e;

    localparam logic [2:0] CODE_PASSIVE = 3'b111;
    localparam logic [2:0] CODE_IO_RD   = 3'b001;
    localparam logic [2:0] CODE_IO_WR   = 3'b010;
    localparam logic [2:0] CODE_MEM_RD  = 3'b101;
    localparam logic [2:0] CODE_MEM_WR  = 3'b110;

    function automatic logic [2:0] cycle_code(input logic is_io, input logic is_wr);
        if (is_io) return is_wr ? CODE_IO_WR : CODE_IO_RD;
        return is_wr ? CODE_MEM_WR : CODE_MEM_RD;
    endfunction

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   hold_req,
    input  logic   ready,
    input  logic   split_pend,
    output phase_e phase,
    output logic   accept,
    output logic   split_step,
    output logic   capture,
    output logic   done,
    output logic   hold_ack
);

    phase_e phase_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // next state
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: begin
                if (hold_req)       phase_nx = PH_HOLD;
                else if (req_valid) phase_nx = PH_ANN;
            end
            PH_ANN:  phase_nx = PH_T1;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3, PH_TW: phase_nx = ready ? PH_T4 : PH_TW;
            PH_T4: begin
                if (split_pend)     phase_nx = PH_T1;
                else if (hold_req)  phase_nx = PH_HOLD;
                else if (req_valid) phase_nx = PH_T1;
                else                phase_nx = PH_IDLE;
            end
            PH_HOLD: phase_nx = hold_req ? PH_HOLD : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept     = 1'b0;
        split_step = 1'b0;
        capture    = 1'b0;
        done       = 1'b0;
        hold_ack   = 1'b0;
        unique case (phase)
            PH_IDLE: accept = req_valid && !hold_req;
            PH_T3, PH_TW: capture = ready;
            PH_T4: begin
                split_step = split_pend;
                done       = !split_pend;
                accept     = !split_pend && !hold_req && req_valid;
            end
            PH_HOLD: hold_ack = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mbs_req.sv
module mbs_req #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              split_step,
    input  logic              capture,
    input  logic              int_en,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_seg,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_word,
    output logic              r_io,
    output logic              r_wr,
    output logic [1:0]        r_seg,
    output logic              ie_q,
    output logic              split_pend,
    output logic [DATA_W-1:0] wr_bus,
    output logic [DATA_W-1:0] rdata
);

    localparam int BYTE_W = DATA_W / 2;
    localparam int LANES  = DATA_W / BYTE_W;

    logic [ADDR_W-1:0] a_q;
    logic              word_q;
    logic              second_q;
    logic [DATA_W-1:0] wd_q;
    logic [BYTE_W-1:0] byte_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            r_io     <= 1'b0;
            r_wr     <= 1'b0;
            word_q   <= 1'b0;
            wd_q     <= '0;
            r_seg    <= '0;
            second_q <= 1'b0;
            ie_q     <= 1'b0;
        end else begin
            ie_q <= int_en;
            if (accept) begin
                a_q      <= req_addr;
                r_io     <= req_io;
                r_wr     <= req_write;
                word_q   <= req_word;
                wd_q     <= req_wdata;
                r_seg    <= req_seg;
                second_q <= 1'b0;
            end else if (split_step) begin
                second_q <= 1'b1;
            end
        end
    end

    assign split_pend = word_q && a_q[0] && !second_q;
    assign cur_word   = word_q && !a_q[0];
    assign cur_addr   = second_q ? a_q + ADDR_W'(1) : a_q;
    assign byte_val   = second_q ? wd_q[DATA_W-1:BYTE_W] : wd_q[BYTE_W-1:0];

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign wr_bus[ln*BYTE_W +: BYTE_W] = cur_word ? wd_q[ln*BYTE_W +: BYTE_W] : byte_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            if (cur_word)
                rdata <= ad_in;
            else if (second_q)
                rdata[DATA_W-1:BYTE_W] <= ad_in[BYTE_W-1:0];
            else
                rdata <= {{BYTE_W{1'b0}},
                          cur_addr[0] ? ad_in[DATA_W-1:BYTE_W] : ad_in[BYTE_W-1:0]};
        end
    end

endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  phase_e                   phase,
    input  logic                     ready,
    input  logic                     accept,
    input  logic                     split_pend,
    input  logic                     req_io,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic                     cur_word,
    input  logic                     r_io,
    input  logic                     r_wr,
    input  logic [1:0]               r_seg,
    input  logic                     ie_q,
    input  logic [DATA_W-1:0]        wr_bus,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic                     as_oe,
    output logic                     bhe_n,
    output logic                     bhe_oe,
    output logic                     rd_n,
    output logic                     rd_oe,
    output logic [2:0]               status
);

    localparam int UP_W = ADDR_W - DATA_W;

    logic [2:0]      own_code;
    logic [2:0]      next_code;
    logic [UP_W-1:0] stat_bits;

    assign own_code  = cycle_code(r_io, r_wr);
    assign next_code = split_pend ? own_code : cycle_code(req_io, req_write);

    always_comb begin
        stat_bits    = '0;
        stat_bits[2] = ie_q;
        stat_bits[1:0] = r_seg;
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        as_out = '0;
        as_oe  = 1'b1;
        bhe_n  = 1'b1;
        bhe_oe = 1'b1;
        rd_n   = 1'b1;
        rd_oe  = 1'b1;
        status = CODE_PASSIVE;
        unique case (phase)
            PH_IDLE: ;
            PH_ANN:  status = own_code;
            PH_T1: begin
                ad_out = cur_addr[DATA_W-1:0];
                ad_oe  = 1'b1;
                as_out = r_io ? '0 : cur_addr[ADDR_W-1:DATA_W];
                bhe_n  = !(cur_word || cur_addr[0]);
                status = own_code;
            end
            PH_T2: begin
                ad_out = r_wr ? wr_bus : '0;
                ad_oe  = r_wr;
                as_out = stat_bits;
                rd_n   = r_wr;
                status = own_code;
            end
            PH_T3, PH_TW: begin
                ad_out = r_wr ? wr_bus : '0;
                ad_oe  = r_wr;
                as_out = stat_bits;
                rd_n   = r_wr;
                status = ready ? CODE_PASSIVE : own_code;
            end
            PH_T4: begin
                ad_out = r_wr ? wr_bus : '0;
                ad_oe  = r_wr;
                as_out = stat_bits;
                status = (split_pend || accept) ? next_code : CODE_PASSIVE;
            end
            PH_HOLD: begin
                as_oe  = 1'b0;
                bhe_oe = 1'b0;
                rd_oe  = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int UP_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ack,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_seg,
    input  logic              int_en,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              ready,
    input  logic              hold_req,
    output logic              hold_ack,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [UP_W-1:0]   as_out,
    output logic              as_oe,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic              rd_n,
    output logic              rd_oe,
    output logic [2:0]        status
);

    phase_e            phase;
    logic              accept, split_step, capture, split_pend;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_word, r_io, r_wr, ie_q;
    logic [1:0]        r_seg;
    logic [DATA_W-1:0] wr_bus;

    assign req_ack = accept;

    mbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hold_req  (hold_req),
        .ready     (ready),
        .split_pend(split_pend),
        .phase     (phase),
        .accept    (accept),
        .split_step(split_step),
        .capture   (capture),
        .done      (done),
        .hold_ack  (hold_ack)
    );

    mbs_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .split_step(split_step),
        .capture   (capture),
        .int_en    (int_en),
        .req_addr  (req_addr),
        .req_io    (req_io),
        .req_write (req_write),
        .req_word  (req_word),
        .req_wdata (req_wdata),
        .req_seg   (req_seg),
        .ad_in     (ad_in),
        .cur_addr  (cur_addr),
        .cur_word  (cur_word),
        .r_io      (r_io),
        .r_wr      (r_wr),
        .r_seg     (r_seg),
        .ie_q      (ie_q),
        .split_pend(split_pend),
        .wr_bus    (wr_bus),
        .rdata     (rdata)
    );

    mbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase     (phase),
        .ready     (ready),
        .accept    (accept),
        .split_pend(split_pend),
        .req_io    (req_io),
        .req_write (req_write),
        .cur_addr  (cur_addr),
        .cur_word  (cur_word),
        .r_io      (r_io),
        .r_wr      (r_wr),
        .r_seg     (r_seg),
        .ie_q      (ie_q),
        .wr_bus    (wr_bus),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .as_out    (as_out),
        .as_oe     (as_oe),
        .bhe_n     (bhe_n),
        .bhe_oe    (bhe_oe),
        .rd_n      (rd_n),
        .rd_oe     (rd_oe),
        .status    (status)
    );

endmodule

// File: rtl/mbs_chk.sv
module mbs_chk
    import mbs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input phase_e     phase,
    input logic       ready,
    input logic       req_ack,
    input logic       done,
    input logic       hold_ack,
    input logic       ad_oe,
    input logic       as_oe,
    input logic       bhe_oe,
    input logic       rd_oe,
    input logic       rd_n,
    input logic [2:0] status
);

    a_r13_hold_float: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ad_oe && !as_oe && !bhe_oe && !rd_oe && status == CODE_PASSIVE));

    a_r6_strobe_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r9_wait_insert: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && !ready) |=> phase == PH_TW);

    a_r9_wait_end: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && ready) |=> phase == PH_T4);

    a_r8_passive_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && ready) |-> status == CODE_PASSIVE);

    a_r2_done_in_t4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> phase == PH_T4);

    a_r3_t1_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |-> (ad_oe && status != CODE_PASSIVE));

    a_r12_t4_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T4 && req_ack) |=> phase == PH_T1);

endmodule

bind mux_bus_seq mbs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .ready   (ready),
    .req_ack (req_ack),
    .done    (done),
    .hold_ack(hold_ack),
    .ad_oe   (ad_oe),
    .as_oe   (as_oe),
    .bhe_oe  (bhe_oe),
    .rd_oe   (rd_oe),
    .rd_n    (rd_n),
    .status  (status)
);

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [19:0] addr;
        logic        io;
        logic        wr;
        logic        word;
        logic [15:0] wd;
        logic [15:0] rd;
        logic [1:0]  seg;
        logic [2:0]  waits;
        logic        ie;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{20'h12344, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 2'd2, 3'd0, 1'b1},
        '{20'hA0010, 1'b0, 1'b1, 1'b0, 16'h0055, 16'h0000, 2'd1, 3'd1, 1'b0},
        '{20'h00301, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0077, 2'd0, 3'd2, 1'b1},
        '{20'h00080, 1'b1, 1'b1, 1'b1, 16'h1234, 16'h0000, 2'd3, 3'd0, 1'b0},
        '{20'h0FFFF, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hABCD, 2'd1, 3'd1, 1'b1},
        '{20'h20003, 1'b0, 1'b1, 1'b1, 16'h5AA5, 16'h0000, 2'd2, 3'd0, 1'b0},
        '{20'h00007, 1'b0, 1'b1, 1'b0, 16'h0033, 16'h0000, 2'd0, 3'd3, 1'b1},
        '{20'h0F0F1, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h4321, 2'd3, 3'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_seg = '0;
    logic        int_en = 1'b0, ready = 1'b1, hold_req = 1'b0;
    logic [15:0] ad_in = '0;
    logic        req_ack, done, hold_ack, ad_oe, as_oe, bhe_n, bhe_oe, rd_n, rd_oe;
    logic [15:0] rdata, ad_out;
    logic [3:0]  as_out;
    logic [2:0]  status;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
        .req_addr(req_addr), .req_io(req_io), .req_write(req_write), .req_word(req_word),
        .req_wdata(req_wdata), .req_seg(req_seg), .int_en(int_en), .done(done),
        .rdata(rdata), .ready(ready), .hold_req(hold_req), .hold_ack(hold_ack),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .as_out(as_out), .as_oe(as_oe),
        .bhe_n(bhe_n), .bhe_oe(bhe_oe), .rd_n(rd_n), .rd_oe(rd_oe), .status(status)
    );

    function automatic logic [2:0] code_of(input logic io, input logic wr);
        if (io) return wr ? 3'b010 : 3'b001;
        return wr ? 3'b110 : 3'b101;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // One bus cycle from T1 to T4. Called while the DUT is in the clock before T1.
    task automatic bus_cycle(input logic [19:0] ca, input logic io, input logic wr,
                             input logic cw, input logic [15:0] wbus, input logic [15:0] rbus,
                             input int waits, input logic [1:0] seg, input logic ie,
                             input logic [2:0] nxt_code, input logic arm_next,
                             input logic exp_ack, input logic exp_done,
                             input logic [15:0] exp_rd);
        logic [2:0] cd;
        cd = code_of(io, wr);
        @(negedge clk);
        if (!arm_next) req_valid = 1'b0;
        #1;
        chk("R3 T1 ad_oe", ad_oe, 1);
        chk("R3 T1 address", ad_out, ca[15:0]);
        chk("R3 T1 upper lines", as_out, io ? 4'h0 : ca[19:16]);
        chk("R4 T1 bhe_n", bhe_n, !(cw || ca[0]));
        chk("R8 T1 status", status, cd);
        chk("R6 T1 rd_n", rd_n, 1);
        @(negedge clk); #1;
        chk("R8 T2 status", status, cd);
        chk("R6 T2 rd_n", rd_n, wr);
        chk("R6 R7 T2 ad_oe", ad_oe, wr);
        if (wr) chk("R7 T2 write data", ad_out, wbus);
        chk("R5 T2 status lines", as_out, {1'b0, ie, seg});
        chk("R5 T2 bhe_n", bhe_n, 1);
        for (int k = 0; k <= waits; k++) begin
            @(negedge clk);
            ready = (k == waits);
            ad_in = ready ? rbus : 16'hDEAD;
            #1;
            chk("R8 R9 T3/TW status", status, ready ? 3'b111 : cd);
            chk("R6 R9 T3/TW rd_n", rd_n, wr);
            chk("R5 T3/TW status lines", as_out, {1'b0, ie, seg});
            if (wr) chk("R7 T3/TW write data", ad_out, wbus);
            chk("R2 R9 no early done", done, 0);
        end
        @(negedge clk);
        ready = 1'b1;
        ad_in = 16'h0000;
        if (arm_next) req_valid = 1'b1;
        #1;
        chk("R6 T4 rd_n", rd_n, 1);
        chk("R11 R12 T4 status", status, nxt_code);
        chk("R12 T4 req_ack", req_ack, exp_ack);
        chk("R2 T4 done", done, exp_done);
        if (wr) chk("R7 T4 write data", ad_out, wbus);
        if (exp_done && !wr) chk("R10 read data", rdata, exp_rd);
    endtask

    task automatic start_req(input logic [19:0] a, input logic io, input logic wr,
                             input logic wd_word, input logic [15:0] wd, input logic [1:0] seg);
        @(negedge clk);
        req_addr = a; req_io = io; req_write = wr; req_word = wd_word;
        req_wdata = wd; req_seg = seg; req_valid = 1'b1;
        #1;
        chk("R2 idle accept", req_ack, 1);
        chk("R8 idle passive", status, 3'b111);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R2 R8 announce status", status, code_of(io, wr));
        chk("R2 announce ad_oe", ad_oe, 0);
        chk("R2 announce rd_n", rd_n, 1);
    endtask

    task automatic run_vec(input vec_t v);
        logic [2:0] cd;
        cd = code_of(v.io, v.wr);
        int_en = v.ie;
        start_req(v.addr, v.io, v.wr, v.word, v.wd, v.seg);
        if (v.word && v.addr[0]) begin
            bus_cycle(v.addr, v.io, v.wr, 1'b0, {v.wd[7:0], v.wd[7:0]}, {v.rd[7:0], 8'h33},
                      int'(v.waits), v.seg, v.ie, cd, 1'b0, 1'b0, 1'b0, 16'h0);
            bus_cycle(v.addr + 20'd1, v.io, v.wr, 1'b0, {v.wd[15:8], v.wd[15:8]},
                      {8'h44, v.rd[15:8]}, int'(v.waits), v.seg, v.ie, 3'b111,
                      1'b0, 1'b0, 1'b1, v.rd);
        end else begin
            bus_cycle(v.addr, v.io, v.wr, v.word,
                      v.word ? v.wd : {v.wd[7:0], v.wd[7:0]},
                      v.word ? v.rd : (v.addr[0] ? {v.rd[7:0], 8'h11} : {8'h22, v.rd[7:0]}),
                      int'(v.waits), v.seg, v.ie, 3'b111, 1'b0, 1'b0, 1'b1,
                      v.word ? v.rd : {8'h00, v.rd[7:0]});
        end
        @(negedge clk); #1;
        chk("R2 back to idle status", status, 3'b111);
        chk("R2 back to idle ad_oe", ad_oe, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rd_n", rd_n, 1);
        chk("R1 bhe_n", bhe_n, 1);
        chk("R1 status", status, 3'b111);
        chk("R1 ad_oe", ad_oe, 0);
        chk("R1 as_oe", as_oe, 1);
        chk("R1 hold_ack", hold_ack, 0);
        chk("R1 done", done, 0);

        for (int i = 0; i < 8; i++) run_vec(VECS[i]);

        // R13 hold from idle refuses requests and floats the bus
        @(negedge clk);
        hold_req = 1'b1; req_valid = 1'b1; req_addr = 20'h00400;
        req_io = 1'b0; req_write = 1'b0; req_word = 1'b1;
        #1;
        chk("R13 refused in idle", req_ack, 0);
        @(negedge clk); #1;
        chk("R13 hold_ack", hold_ack, 1);
        chk("R13 ad_oe float", ad_oe, 0);
        chk("R13 as_oe float", as_oe, 0);
        chk("R13 bhe_oe float", bhe_oe, 0);
        chk("R13 rd_oe float", rd_oe, 0);
        chk("R13 status passive", status, 3'b111);
        chk("R13 refused in hold", req_ack, 0);
        @(negedge clk);
        hold_req = 1'b0; req_valid = 1'b0;
        @(negedge clk); #1;
        chk("R13 hold released", hold_ack, 0);
        chk("R13 as_oe restored", as_oe, 1);

        // R12 back-to-back: second request taken in T4, no announce clock
        int_en = 1'b0;
        start_req(20'h00100, 1'b0, 1'b0, 1'b1, 16'h0000, 2'd0);
        req_addr = 20'h00041; req_io = 1'b1; req_write = 1'b1; req_word = 1'b0;
        req_wdata = 16'h0099; req_seg = 2'd3;
        bus_cycle(20'h00100, 1'b0, 1'b0, 1'b1, 16'h0, 16'h1111, 0, 2'd0, 1'b0,
                  3'b010, 1'b1, 1'b1, 1'b1, 16'h1111);
        bus_cycle(20'h00041, 1'b1, 1'b1, 1'b0, 16'h9999, 16'h0, 1, 2'd3, 1'b0,
                  3'b111, 1'b0, 1'b0, 1'b1, 16'h0);
        @(negedge clk); #1;
        chk("R12 idle after chain", status, 3'b111);

        // R11 R13 split completes before a hold taken at its final T4
        start_req(20'h00011, 1'b0, 1'b1, 1'b1, 16'hC3D4, 2'd1);
        hold_req = 1'b1;
        bus_cycle(20'h00011, 1'b0, 1'b1, 1'b0, 16'hD4D4, 16'h0, 0, 2'd1, 1'b0,
                  3'b110, 1'b0, 1'b0, 1'b0, 16'h0);
        bus_cycle(20'h00012, 1'b0, 1'b1, 1'b0, 16'hC3C3, 16'h0, 0, 2'd1, 1'b0,
                  3'b111, 1'b0, 1'b0, 1'b1, 16'h0);
        @(negedge clk); #1;
        chk("R13 hold after split", hold_ack, 1);
        chk("R13 ad float after split", ad_oe, 0);
        @(negedge clk);
        hold_req = 1'b0;
        @(negedge clk); #1;
        chk("R13 released after split", hold_ack, 0);

        summary();
    end

endmodule